// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines from peripherals, resolves them under a fixed priority and raises one interrupt output toward a processor. It keeps three state vectors: a pending-request vector, an in-service vector and a mask vector. The interrupt output is raised only when the best unmasked pending line outranks every line already being serviced. A service routine at a higher level can therefore preempt a lower one, while a lower level waits.

The processor answers with a one-cycle acknowledge pulse. On that pulse the winning line moves into the in-service vector, and an 8-bit vector is formed from a programmable five-bit base and the three-bit line number. Software reaches the block through synchronous select, read and write strobes and one address bit. It uses them to load the mask, set up the trigger mode and the vector base, issue end-of-interrupt commands, and read back any of the three vectors.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, `vector` is 0, and the pending, in-service and mask vectors read back as 0. The trigger mode is edge and the read select points at the pending vector.
- R2: Each request line passes a two-flop synchronizer. In level mode, `irq_out` rises after the third rising clock edge following a change on an idle input, and not earlier.
- R3: In edge mode, a line becomes pending on a low-to-high transition of its synchronized input. It stops pending when the input falls or when it is acknowledged. A line held high after its acknowledge does not request again.
- R4: In level mode, a high input alone is a request. A line still held high after its end-of-interrupt requests again.
- R5: Priority is fixed, with line 0 highest and line 7 lowest. The acknowledged line is the lowest-index pending, unmasked line.
- R6: An address-1 write, when no base load is armed, loads the mask from bits 7..0 (1 means masked). An address-1 read returns the mask. A masked line never raises `irq_out`, and masking a line does not block lines of lower priority.
- R7: `irq_out` is 1 exactly when some pending unmasked line exists whose index is lower than the lowest set in-service index, or when a pending unmasked line exists and nothing is in service.
- R8: `ack` works whether or not `sel` is asserted. On the edge where `ack` is high with a valid request, the in-service bit of the winning line is set, and from the next cycle `vector` = {base[4:0], line[2:0]}.
- R9: If `ack` arrives with no valid request, `vector` becomes {base, 3'b111} and the in-service vector is left unchanged.
- R10: An address-0 write with bit 4 clear and bit 5 set is an end-of-interrupt. It clears the lowest-index set in-service bit. If `ack` arrives in the same cycle, the end-of-interrupt acts on the old in-service vector and the acknowledged bit is then added.
- R11: An address-0 write with bit 4 set is a setup command. It selects level mode if bit 3 is 1 and edge mode if bit 3 is 0, clears the mask and the in-service vector, and arms a base load. The next address-1 write then loads the base from bits 7..3 instead of loading the mask.
- R12: An address-0 write with bit 4 clear and bit 1 set sets the read select from bit 0 (0 selects pending, 1 selects in-service). An address-0 read returns the selected vector. Read data appears on `rdata` the cycle after the strobe. A read strobe without `sel` leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Asynchronous request lines, line 0 highest priority |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, one cycle, qualified by sel |
| rd | input | 1 | Read strobe, one cycle, qualified by sel |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ack | input | 1 | Interrupt acknowledge pulse, one cycle |
| irq_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledge |

## Verification
An acknowledge and an end-of-interrupt write can land on the same clock edge. In that case one edge both removes an old in-service bit and inserts a new one.

The bench provokes this case by placing line 3 in service, raising line 1 so that it preempts, and then pulsing `ack` during the end-of-interrupt write. The result is judged by reading back the in-service vector, which must hold only line 1, and by checking that the vector carries line 1.

Acknowledges that meet a mask change, or that arrive while nothing valid is pending, are judged through the vector and the read-back state.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned NUM_LINES = 8;
    localparam int unsigned IDX_W     = $clog2(NUM_LINES);
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned BASE_W    = VEC_W - IDX_W;

    typedef struct packed {
        logic [NUM_LINES-1:0] req;
        logic [NUM_LINES-1:0] isr;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] prev;
        logic [BASE_W-1:0]    base;
        logic                 lvl_mode;
        logic                 rd_isr;
        logic                 base_armed;
        logic [VEC_W-1:0]     vector;
        logic [VEC_W-1:0]     rdata;
    } ctrl_state_t;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 sel,
    input  logic                 wr,
    input  logic                 rd,
    input  logic                 addr,
    input  logic [VEC_W-1:0]     wdata,
    output logic [VEC_W-1:0]     rdata,
    input  logic                 ack,
    output logic                 irq_out,
    output logic [VEC_W-1:0]     vector
);
    ctrl_state_t st_q, st_d;

    logic [NUM_LINES-1:0] line_s;
    logic [NUM_LINES-1:0] pend;
    logic                 pend_found, isr_found;
    logic [IDX_W-1:0]     pend_idx, isr_idx;
    logic                 win_ok;
    logic                 wr_cmd, wr_hi, rd_go;

    irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(line_s)
    );

    assign pend = st_q.req & ~st_q.mask;

    irq_prio_pick #(.WIDTH(NUM_LINES)) u_pick_pend (
        .bits(pend), .found(pend_found), .idx(pend_idx)
    );

    irq_prio_pick #(.WIDTH(NUM_LINES)) u_pick_isr (
        .bits(st_q.isr), .found(isr_found), .idx(isr_idx)
    );

    assign win_ok = pend_found && (!isr_found || (pend_idx < isr_idx));
    assign wr_cmd = sel && wr && !addr;
    assign wr_hi  = sel && wr && addr;
    assign rd_go  = sel && rd;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line_s;

        // request capture
        if (st_q.lvl_mode) st_d.req = line_s;
        else               st_d.req = line_s & (st_q.req | ~st_q.prev);

        // command port, address 0
        if (wr_cmd) begin
            if (wdata[4]) begin
                st_d.lvl_mode   = wdata[3];
                st_d.mask       = '0;
                st_d.isr        = '0;
                st_d.base_armed = 1'b1;
            end else begin
                if (wdata[5] && isr_found) st_d.isr[isr_idx] = 1'b0;
                if (wdata[1])              st_d.rd_isr = wdata[0];
            end
        end

        // data port, address 1
        if (wr_hi) begin
            if (st_q.base_armed) begin
                st_d.base       = wdata[VEC_W-1:IDX_W];
                st_d.base_armed = 1'b0;
            end else begin
                st_d.mask = wdata;
            end
        end

        // acknowledge, independent of sel
        if (ack) begin
            if (win_ok) begin
                st_d.isr[pend_idx] = 1'b1;
                if (!st_q.lvl_mode) st_d.req[pend_idx] = 1'b0;
                st_d.vector = {st_q.base, pend_idx};
            end else begin
                st_d.vector = {st_q.base, {IDX_W{1'b1}}};
            end
        end

        if (rd_go) begin
            if (addr)             st_d.rdata = st_q.mask;
            else if (st_q.rd_isr) st_d.rdata = st_q.isr;
            else                  st_d.rdata = st_q.req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = win_ok;
    assign vector  = st_q.vector;
    assign rdata   = st_q.rdata;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ack,
    input logic                 sel,
    input logic                 wr,
    input logic                 rd,
    input logic                 addr,
    input logic                 irq_out,
    input logic [VEC_W-1:0]     vector,
    input logic [VEC_W-1:0]     rdata,
    input logic [NUM_LINES-1:0] req,
    input logic [NUM_LINES-1:0] isr,
    input logic [NUM_LINES-1:0] mask
);
    AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((req & ~mask) != '0)); // R7
    AST_ACK_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out) |=> isr[vector[IDX_W-1:0]]); // R8
    AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && !(sel && wr)) |=> ((vector[IDX_W-1:0] == {IDX_W{1'b1}}) && $stable(isr))); // R9
    AST_ISR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !(sel && wr)) |=> $stable(isr)); // R10
    AST_MASK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr) |=> (rdata == $past(mask))); // R6
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .irq_out(irq_out), .vector(vector), .rdata(rdata),
    .req(st_q.req), .isr(st_q.isr), .mask(st_q.mask)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, vector;
    logic       irq_out;
    int         checks = 0, errors = 0;
    bit         done = 0;

    localparam logic [7:0] BASE_BYTE = 8'hA8;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sel(sel), .wr(wr),
        .rd(rd), .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack),
        .irq_out(irq_out), .vector(vector)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = 7;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        sel = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic setup(input logic level);
        bus_wr(1'b0, level ? 8'h18 : 8'h10);
        bus_wr(1'b1, BASE_BYTE);
    endtask

    task automatic rd_isr_sel(input logic isr_view);
        bus_wr(1'b0, isr_view ? 8'h03 : 8'h02);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
        chk("R1 vector", vector, 8'h00);
        bus_rd(1'b0, d); chk("R1 pending", d, 8'h00);
        bus_rd(1'b1, d); chk("R1 mask", d, 8'h00);
        rd_isr_sel(1'b1);
        bus_rd(1'b0, d); chk("R1 isr", d, 8'h00);
        rd_isr_sel(1'b0);

        // R11 setup in level mode and load base
        bus_wr(1'b1, 8'h0F);
        setup(1'b1);
        bus_rd(1'b1, d); chk("R11 mask cleared, base not in mask", d, 8'h00);

        // R2 synchronizer latency
        irq_in = 8'h10;
        wait_n(2); chk("R2 not before third edge", {7'd0, irq_out}, 8'h00);
        wait_n(1); chk("R2 at third edge", {7'd0, irq_out}, 8'h01);
        irq_in = 8'h00; wait_n(4);

        // R5 R7 R8 R10 R12: sweep every request pattern in level mode
        for (int p = 0; p < 256; p++) begin
            irq_in = p[7:0];
            wait_n(4);
            chk("R7 irq_out vs pending", {7'd0, irq_out}, {7'd0, (p != 0)});
            rd_isr_sel(1'b0);
            bus_rd(1'b0, d); chk("R12 pending read", d, p[7:0]);
            if (p != 0) begin
                pulse_ack();
                chk("R5 R8 vector", vector, BASE_BYTE | 8'(lowest(p[7:0])));
                chk("R7 no outranking after ack", {7'd0, irq_out}, 8'h00);
                rd_isr_sel(1'b1);
                bus_rd(1'b0, d); chk("R8 isr bit", d, 8'h01 << lowest(p[7:0]));
                bus_wr(1'b0, 8'h20);
                bus_rd(1'b0, d); chk("R10 eoi clears", d, 8'h00);
            end
            irq_in = 8'h00;
            wait_n(4);
        end

        // R7 R10 preemption over all ordered pairs
        rd_isr_sel(1'b1);
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a != b) begin
                    irq_in = 8'h01 << a; wait_n(4);
                    pulse_ack();
                    irq_in = irq_in | (8'h01 << b); wait_n(4);
                    chk("R7 preempt only if higher", {7'd0, irq_out}, {7'd0, (b < a)});
                    if (b < a) begin
                        pulse_ack();
                        chk("R8 nested vector", vector, BASE_BYTE | 8'(b));
                        bus_wr(1'b0, 8'h20);
                        bus_rd(1'b0, d); chk("R10 eoi clears highest", d, 8'h01 << a);
                    end
                    bus_wr(1'b0, 8'h20);
                    bus_rd(1'b0, d); chk("R10 isr empty", d, 8'h00);
                    irq_in = 8'h00; wait_n(4);
                end
            end
        end

        // R6 mask sweep with all lines requesting
        irq_in = 8'hFF;
        for (int m = 0; m < 256; m++) begin
            bus_wr(1'b1, m[7:0]);
            bus_rd(1'b1, d); chk("R6 mask readback", d, m[7:0]);
            wait_n(1);
            chk("R6 masked lines", {7'd0, irq_out}, {7'd0, (m != 255)});
            if (m != 255) begin
                pulse_ack();
                chk("R6 lower line still served", vector, BASE_BYTE | 8'(lowest(~m[7:0])));
                bus_wr(1'b0, 8'h20);
            end
        end
        bus_wr(1'b1, 8'h00);
        irq_in = 8'h00; wait_n(4);

        // R9 spurious acknowledges
        pulse_ack();
        chk("R9 spurious vector", vector, BASE_BYTE | 8'h07);
        bus_rd(1'b0, d); chk("R9 isr unchanged", d, 8'h00);
        bus_wr(1'b1, 8'h01); irq_in = 8'h01; wait_n(4);
        pulse_ack();
        chk("R9 masked-only spurious", vector, BASE_BYTE | 8'h07);
        bus_rd(1'b0, d); chk("R9 isr unchanged masked", d, 8'h00);
        bus_wr(1'b1, 8'h00); irq_in = 8'h00; wait_n(4);

        // R10 acknowledge and end-of-interrupt on the same edge
        irq_in = 8'h08; wait_n(4);
        pulse_ack();
        irq_in = 8'h0A; wait_n(4);
        chk("R7 line 1 preempts 3", {7'd0, irq_out}, 8'h01);
        sel = 1'b1; wr = 1'b1; addr = 1'b0; wdata = 8'h20; ack = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; ack = 1'b0;
        chk("R10 same-edge vector", vector, BASE_BYTE | 8'h01);
        bus_rd(1'b0, d); chk("R10 same-edge isr", d, 8'h02);
        bus_wr(1'b0, 8'h20);

        // R11 setup clears in-service
        pulse_ack();
        setup(1'b1);
        bus_rd(1'b0, d); chk("R11 setup clears isr", d, 8'h00);

        // R4 level line re-requests after eoi
        irq_in = 8'h04; wait_n(4);
        pulse_ack();
        bus_wr(1'b0, 8'h20); wait_n(4);
        chk("R4 level re-request", {7'd0, irq_out}, 8'h01);
        irq_in = 8'h00; wait_n(4);

        // R3 edge mode
        setup(1'b0);
        irq_in = 8'h04; wait_n(4);
        chk("R3 edge request", {7'd0, irq_out}, 8'h01);
        pulse_ack();
        chk("R3 edge vector", vector, BASE_BYTE | 8'h02);
        bus_wr(1'b0, 8'h20); wait_n(4);
        chk("R3 held line no re-request", {7'd0, irq_out}, 8'h00);
        rd_isr_sel(1'b0);
        bus_rd(1'b0, d); chk("R3 pending cleared by ack", d, 8'h00);
        irq_in = 8'h00; wait_n(4);
        irq_in = 8'h04; wait_n(4);
        chk("R3 new edge requests", {7'd0, irq_out}, 8'h01);
        irq_in = 8'h00; wait_n(4);
        chk("R3 falling line withdraws", {7'd0, irq_out}, 8'h00);

        // R12 read without sel leaves rdata unchanged
        bus_wr(1'b1, 8'h5A);
        bus_rd(1'b1, d); chk("R6 mask load", d, 8'h5A);
        rd = 1'b1; addr = 1'b0; @(negedge clk); rd = 1'b0;
        chk("R12 read needs sel", rdata, 8'h5A);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule